// File: doc/BRIEF.md
# Serial Command Word Receiver with Chain Forwarding

This block is a three-wire serial slave that turns 24-bit command words into parallel fields. The pins are an active-low frame sync, a serial clock and serial data-in, plus a data-out pin. The data-out pin lets several receivers share one serial bus in a chain. All three input pins are oversampled in a faster system clock domain. Edges of the sync and serial clock are detected there, and data-in is taken on each detected falling edge of the serial clock.

Each received word splits into a 2-bit register select, an 8-bit address and a 14-bit data value. A completed word is announced with a pulse on `cmd_valid` that lasts one system clock. The decoded fields stay on the outputs until the next word arrives.

A mode input chooses between two framing schemes. In standalone mode, a falling sync edge opens a frame and exactly 24 bits are counted. In chained mode, bits shift in for as long as sync is low, and the word is captured when sync rises. In chained mode, bits pushed past the 24th position come out on the data-out pin, so they can feed the next receiver in the chain.

Top module: `cmd_deserializer`

## Requirements
- R1: Bits arrive MSB first. Of the 24 bits, the first two form `cmd_sel` (first bit is bit 1). The next eight form `cmd_addr`, bit 7 first. The last fourteen form `cmd_data`, bit 13 first.
- R2: Standalone mode (`daisy_en`=0): a falling edge of `fsync_n` starts a frame. `cmd_valid` pulses once, shortly after the 24th falling edge of `sclk`, carrying the 24 bits sampled on those edges.
- R3: Standalone mode: sync edges that occur before the 24th bit do not restart or shorten the frame. After the 24th bit, `sclk` edges produce no pulse and leave the fields unchanged until the next sync falling edge.
- R4: Standalone mode accepts a burst clock with pauses inside a frame. It also accepts a free-running clock whose edges outside a frame are ignored.
- R5: Chained mode (`daisy_en`=1): while `fsync_n` is low, every falling `sclk` edge shifts `sdi` in. On the rising edge of `fsync_n`, `cmd_valid` pulses with the last 24 bits shifted in.
- R6: Chained mode: a frame that had fewer than 24 falling `sclk` edges while sync was low produces no pulse, and the fields keep their old values.
- R7: In chained mode, `sdo` changes only after a rising `sclk` edge. It shows the bit that was shifted in 24 falling edges earlier, and 0 for the first 24 bits after a sync falling edge. In standalone mode, `sdo` stays 0.
- R8: `cmd_valid` is never high for two system clocks in a row. `cmd_sel`, `cmd_addr` and `cmd_data` hold their values between pulses.
- R9: After reset, `cmd_valid`, `sdo` and all field outputs are 0.
- R10: Chained mode: `sclk` edges while `fsync_n` is high do not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| daisy_en | input | 1 | 0 = standalone framing, 1 = chained framing |
| fsync_n | input | 1 | Active-low frame sync |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out toward the next receiver in the chain |
| cmd_valid | output | 1 | One-cycle pulse marking a new command word |
| cmd_sel | output | SEL_W | Register select field |
| cmd_addr | output | ADDR_W | Address field |
| cmd_data | output | DATA_W | Data field |

## Verification
The assertions assume that each half period of `sclk` lasts at least three system clocks. They also assume that `sdi` is stable around each falling edge of `sclk`, that no sync edge lands in the same system cycle as a serial clock edge, and that `daisy_en` changes only while sync is idle. The stimulus meets these conditions by using six-cycle serial half periods and by setting data half a period before each falling edge. It spaces every sync transition at least a half period away from any clock edge, and it switches modes only between frames with sync held high.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  // Lane positions of the serial pins inside the synchronizer vector
  localparam int LANE_FS = 0;
  localparam int LANE_CK = 1;
  localparam int LANE_DI = 2;
  localparam int LANES   = 3;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } fr_state_e;

endpackage

// File: rtl/cmdrx_pin_sync.sv
module cmdrx_pin_sync #(
  parameter int               LANES   = 3,
  parameter int               STAGES  = 2,
  parameter logic [LANES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] lvl_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign lvl_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cmdrx_edge.sv
module cmdrx_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/cmdrx_framer.sv
module cmdrx_framer
  import cmdrx_pkg::*;
#(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               daisy_i,
  input  logic               din_i,
  input  logic               fs_low_i,
  input  logic               fs_fall_i,
  input  logic               fs_rise_i,
  input  logic               ck_fall_i,
  input  logic               ck_rise_i,
  output logic               stb_o,
  output logic [FRAME_W-1:0] word_o,
  output logic               dout_o
);

  localparam int              CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  fr_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d, shifted;
  logic [FRAME_W-1:0] word_q;
  logic               shreg_en, word_en;
  logic               stb_q, stb_d;
  logic               dout_q, dout_d;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    shreg_en = 1'b0;
    word_en  = 1'b0;
    stb_d    = 1'b0;
    dout_d   = dout_q;
    shifted  = {shreg_q[FRAME_W-2:0], din_i};

    if (!daisy_i) begin
      // Counted framing: exactly FRAME_W bits after a sync fall
      dout_d = 1'b0;
      unique case (state_q)
        FR_IDLE, FR_DONE: begin
          if (fs_fall_i) begin
            state_d = FR_SHIFT;
            cnt_d   = '0;
          end
        end
        FR_SHIFT: begin
          if (ck_fall_i) begin
            shreg_d  = shifted;
            shreg_en = 1'b1;
            cnt_d    = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              word_en = 1'b1;
              stb_d   = 1'b1;
              state_d = FR_DONE;
            end
          end
        end
        default: state_d = FR_IDLE;
      endcase
    end else begin
      // Chained framing: shift while sync low, capture on sync rise
      if (fs_fall_i) begin
        state_d  = FR_SHIFT;
        cnt_d    = '0;
        shreg_d  = '0;
        shreg_en = 1'b1;
      end else if (state_q == FR_SHIFT) begin
        if (fs_rise_i) begin
          state_d = FR_IDLE;
          if (cnt_q == CNT_FULL) begin
            word_en = 1'b1;
            stb_d   = 1'b1;
          end
        end else if (fs_low_i && ck_fall_i) begin
          shreg_d  = shifted;
          shreg_en = 1'b1;
          if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
        end
      end
      if (ck_rise_i) dout_d = shreg_q[FRAME_W-1];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stb_q   <= stb_d;
      dout_q  <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '0;
    else if (shreg_en) shreg_q <= shreg_d;
  end

  // In standalone mode the captured word is the freshly shifted value,
  // in chained mode it is the shift register as it stands at sync rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= daisy_i ? shreg_q : shifted;
  end

  assign stb_o  = stb_q;
  assign word_o = word_q;
  assign dout_o = dout_q;

  // R8
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R5
  daisy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && $past(daisy_i)) |-> $past(fs_rise_i));

  // R2
  solo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !$past(daisy_i)) |-> $past(ck_fall_i));

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(daisy_i) && daisy_i && !$past(ck_rise_i)) |-> $stable(dout_q));

  // R6
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

endmodule

// File: rtl/cmd_deserializer.sv
module cmd_deserializer
  import cmdrx_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              daisy_en,
  input  logic              fsync_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              cmd_valid,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int FRAME_W = SEL_W + ADDR_W + DATA_W;
  localparam logic [LANES-1:0] PIN_IDLE = LANES'(3'b011);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [LANES-1:0] pins, lvl;
  logic             fs_rise, fs_fall, ck_rise, ck_fall;
  logic [FRAME_W-1:0] word;

  always_comb begin
    pins          = '0;
    pins[LANE_FS] = fsync_n;
    pins[LANE_CK] = sclk;
    pins[LANE_DI] = sdi;
  end

  cmdrx_pin_sync #(
    .LANES  (LANES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .pin_i(pins),
    .lvl_o(lvl)
  );

  cmdrx_edge #(.RST_VAL(PIN_IDLE[LANE_FS])) u_fs_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl_i (lvl[LANE_FS]),
    .rise_o(fs_rise),
    .fall_o(fs_fall)
  );

  cmdrx_edge #(.RST_VAL(PIN_IDLE[LANE_CK])) u_ck_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl_i (lvl[LANE_CK]),
    .rise_o(ck_rise),
    .fall_o(ck_fall)
  );

  cmdrx_framer #(.FRAME_W(FRAME_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .daisy_i  (daisy_en),
    .din_i    (lvl[LANE_DI]),
    .fs_low_i (~lvl[LANE_FS]),
    .fs_fall_i(fs_fall),
    .fs_rise_i(fs_rise),
    .ck_fall_i(ck_fall),
    .ck_rise_i(ck_rise),
    .stb_o    (cmd_valid),
    .word_o   (word),
    .dout_o   (sdo)
  );

  // R1: field order inside the word, first bit received at the top
  assign cmd_sel  = word[FRAME_W-1 -: SEL_W];
  assign cmd_addr = word[DATA_W +: ADDR_W];
  assign cmd_data = word[DATA_W-1:0];

  // R8
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cmd_valid |-> $stable(word));

endmodule

// File: tb/cmd_deserializer_bench.sv
module cmd_deserializer_bench;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n, daisy_en, fsync_n, sclk, sdi;
  logic        sdo, cmd_valid;
  logic [1:0]  cmd_sel;
  logic [7:0]  cmd_addr;
  logic [13:0] cmd_data;

  logic [23:0] exp_q[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  int          n_pulse = 0;
  bit          prev_valid = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cmd_deserializer u_cmd_deserializer (
    .clk(clk), .rst_n(rst_n), .daisy_en(daisy_en), .fsync_n(fsync_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .cmd_valid(cmd_valid),
    .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Monitor: pop expected words as pulses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cmd_valid) begin
        n_pulse++;
        if (prev_valid) check(1'b0, "R8", "pulse longer than one cycle", 32'd2, 32'd1);
        if (exp_q.size() == 0)
          check(1'b0, "R6", "unexpected pulse", {8'h0, cmd_sel, cmd_addr, cmd_data}, 32'h0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check({cmd_sel, cmd_addr, cmd_data} == e, "R1", "word fields",
                {8'h0, cmd_sel, cmd_addr, cmd_data}, {8'h0, e});
        end
      end
      prev_valid = cmd_valid;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b, input bit chk, input logic expd);
    sdi = b;
    wait_n(H);
    if (chk) check(sdo === expd, "R7", "sdo before fall", {31'h0, sdo}, {31'h0, expd});
    sclk = 1'b0;
    wait_n(H);
    sclk = 1'b1;
  endtask

  task automatic free_clocks(input int n, input logic b);
    for (int i = 0; i < n; i++) tx_bit(b, 1'b0, 1'b0);
  endtask

  task automatic solo_frame(input logic [23:0] w, input int gap);
    exp_q.push_back(w);
    fsync_n = 1'b0;
    wait_n(H);
    for (int i = 23; i >= 0; i--) begin
      tx_bit(w[i], 1'b0, 1'b0);
      if (gap > 0 && i == 12) wait_n(gap);
    end
    wait_n(H);
    fsync_n = 1'b1;
    wait_n(3 * H);
  endtask

  task automatic daisy_frame(input logic [47:0] v, input int n);
    fsync_n = 1'b0;
    wait_n(H);
    for (int k = 0; k < n; k++) begin
      logic expd;
      expd = (k >= 24) ? v[n - 1 - (k - 24)] : 1'b0;
      tx_bit(v[n - 1 - k], k >= 1, expd);
    end
    wait_n(H);
    fsync_n = 1'b1;
    wait_n(3 * H);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; daisy_en = 1'b0; fsync_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R9
    check(cmd_valid == 1'b0, "R9", "valid after reset", {31'h0, cmd_valid}, 32'h0);
    check(sdo == 1'b0, "R9", "sdo after reset", {31'h0, sdo}, 32'h0);
    check({cmd_sel, cmd_addr, cmd_data} == 24'h0, "R9", "fields after reset",
          {8'h0, cmd_sel, cmd_addr, cmd_data}, 32'h0);

    // R1 and R2: standalone frames
    base = n_pulse;
    solo_frame(24'hE96001, 0);
    check(cmd_sel == 2'b11, "R1", "sel field", {30'h0, cmd_sel}, 32'h3);
    check(cmd_addr == 8'hA5, "R1", "addr field", {24'h0, cmd_addr}, 32'hA5);
    check(cmd_data == 14'h2001, "R1", "data field", {18'h0, cmd_data}, 32'h2001);
    solo_frame(24'h555555, 0);
    solo_frame(24'h2AAAAA, 0);
    check(n_pulse == base + 3, "R2", "standalone pulse count", n_pulse - base, 32'd3);

    // R4: burst pause inside a frame, then free-running clock around a frame
    solo_frame(24'h5A3C96, 40);
    free_clocks(5, 1'b1);
    solo_frame(24'h13579B, 0);
    free_clocks(5, 1'b0);
    check({cmd_sel, cmd_addr, cmd_data} == 24'h13579B, "R4", "free-running clock word",
          {8'h0, cmd_sel, cmd_addr, cmd_data}, 32'h13579B);

    // R3: sync toggle mid-frame ignored, extra clocks after 24 bits ignored
    begin
      logic [23:0] w;
      w = 24'hC3E00F;
      base = n_pulse;
      exp_q.push_back(w);
      fsync_n = 1'b0;
      wait_n(H);
      for (int i = 23; i >= 14; i--) tx_bit(w[i], 1'b0, 1'b0);
      wait_n(H); fsync_n = 1'b1; wait_n(2 * H); fsync_n = 1'b0; wait_n(H);
      for (int i = 13; i >= 0; i--) tx_bit(w[i], 1'b0, 1'b0);
      free_clocks(6, 1'b1);
      wait_n(H);
      fsync_n = 1'b1;
      wait_n(3 * H);
      check(n_pulse == base + 1, "R3", "pulses for interrupted frame", n_pulse - base, 32'd1);
      check({cmd_sel, cmd_addr, cmd_data} == w, "R3", "word after extra clocks",
            {8'h0, cmd_sel, cmd_addr, cmd_data}, {8'h0, w});
    end

    // R8 hold and R7 standalone sdo
    wait_n(20);
    check({cmd_sel, cmd_addr, cmd_data} == 24'hC3E00F, "R8", "fields hold",
          {8'h0, cmd_sel, cmd_addr, cmd_data}, 32'hC3E00F);
    check(sdo == 1'b0, "R7", "sdo in standalone", {31'h0, sdo}, 32'h0);

    // R10 and R5: chained mode
    daisy_en = 1'b1;
    wait_n(H);
    free_clocks(5, 1'b1);
    base = n_pulse;
    exp_q.push_back(24'h9C3A71);
    daisy_frame({24'h0, 24'h9C3A71}, 24);
    check(n_pulse == base + 1, "R5", "chained pulse count", n_pulse - base, 32'd1);
    check({cmd_sel, cmd_addr, cmd_data} == 24'h9C3A71, "R10", "word after idle clocks",
          {8'h0, cmd_sel, cmd_addr, cmd_data}, 32'h9C3A71);

    // R5 and R7: 48 bits, last 24 captured, first 24 forwarded on sdo
    base = n_pulse;
    exp_q.push_back(24'hB7E1D2);
    daisy_frame({24'h123456, 24'hB7E1D2}, 48);
    check(n_pulse == base + 1, "R5", "long chain pulse count", n_pulse - base, 32'd1);

    // R6: short frame dropped
    base = n_pulse;
    daisy_frame({24'h0, 24'hFFFFFF}, 20);
    check(n_pulse == base, "R6", "short frame pulses", n_pulse - base, 32'd0);
    check({cmd_sel, cmd_addr, cmd_data} == 24'hB7E1D2, "R6", "fields after short frame",
          {8'h0, cmd_sel, cmd_addr, cmd_data}, 32'hB7E1D2);

    wait_n(10);
    check(exp_q.size() == 0, "R2", "expected words left", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule